// File: doc/BRIEF.md
# Parallel-Translate Set-Associative Cache Read Path

This block is the read-lookup path of a first-level cache whose set index is taken from address bits that lie inside the page offset. Because those bits are the same before and after translation, the tag/data array read and the translation-buffer search start in the same cycle from one virtual address. At the end of that cycle the translated physical page number and the stored tags of every way are captured. In the following cycle the physical page number is compared against all ways at once to produce hit, way and the addressed data word.

A small fully-associative translation buffer maps virtual page numbers to physical page numbers. A set-associative array holds, for each line, a physical page number as its tag, a valid bit and the line data. Both structures are filled through plain write ports driven by refill logic outside the block. Capacity comes from adding ways, never from widening the index past the page offset.

The request side is a valid/ready stream. A request is taken in any cycle where `req_valid` and `req_ready` are both high, and `req_ready` falls only in cycles where one of the refill write ports is active. The response side carries no ready. The consumer must take every response in the cycle it appears, and `req_va` must be held stable while `req_valid` waits for `req_ready`.

Top module: `vipt_lookup`

## Requirements
- R1: After reset, `resp_valid` is low and every translation entry and every cache line is invalid, so a lookup made immediately after reset returns `resp_tlb_miss` high.
- R2: `req_ready` is low in any cycle where `tlb_wr_en` or `line_wr_en` is high, and high otherwise. A request presented with `req_ready` low produces no response.
- R3: An accepted request produces exactly one response, with `resp_valid` high in the following cycle only.
- R4: The set index is `req_va[11:4]`. The returned word is word `req_va[3:2]` of the line, where word 0 occupies line bits [31:0] and word 3 occupies bits [127:96].
- R5: The virtual page number is `req_va[31:12]`. A hit needs a valid translation entry matching it, and a valid line whose stored tag equals the translated physical page number. A line whose tag equals the virtual page number does not hit.
- R6: All four ways of the set are compared at once, and `resp_way` reports the index of the way that hit.
- R7: When no valid translation entry matches, the response has `resp_tlb_miss` high and `resp_hit` low, whatever the tag contents. `resp_tlb_miss` is low in all other cycles.
- R8: Translation-entry writes fill the eight entries in round-robin order starting at entry 0. The ninth write replaces the first mapping, and other mappings are kept.
- R9: A line write with `line_wr_valid` low invalidates that set and way, so later lookups to it miss.
- R10: Whenever `resp_hit` is low, `resp_way` and `resp_data` are zero.
- R11: Elaboration rejects any parameter set where index bits plus block-offset bits exceed the page-offset bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Lookup request can be taken |
| req_va | input | 32 | Virtual byte address |
| resp_valid | output | 1 | Response present this cycle |
| resp_hit | output | 1 | Line found |
| resp_way | output | 2 | Way that hit |
| resp_data | output | 32 | Addressed data word |
| resp_tlb_miss | output | 1 | No translation for the page |
| tlb_wr_en | input | 1 | Write a translation entry |
| tlb_wr_vpn | input | 20 | Virtual page number to write |
| tlb_wr_ppn | input | 20 | Physical page number to write |
| line_wr_en | input | 1 | Write a cache line |
| line_wr_set | input | 8 | Set of the line to write |
| line_wr_way | input | 2 | Way of the line to write |
| line_wr_tag | input | 20 | Physical page tag to store |
| line_wr_valid | input | 1 | Valid bit to store |
| line_wr_data | input | 128 | Line data, word 0 in the low bits |

## Verification
Lookups run against a set shared by several ways whose tags differ. The patterns tell apart the way chosen, the word chosen by the low address bits, and a line whose tag holds the virtual page number instead of the physical one. Addresses with no translation, with a translation but an empty set, and with a matching tag in another set separate translation misses from tag misses. Wrapping the translation buffer past eight writes shows which entry is replaced. Invalidating a line, and offering requests while a write port is busy, cover the valid bit and the back-pressure rule.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  localparam int VA_W   = 32;
  localparam int PA_W   = 32;
  localparam int PG_K   = 12;
  localparam int BLK_B  = 4;
  localparam int IDX_L  = 8;
  localparam int N_WAYS = 4;
  localparam int N_TLB  = 8;
  localparam int WORD_W = 32;
endpackage

// File: rtl/vipt_tlb.sv
module vipt_tlb #(
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20,
  parameter int ENTRIES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [VPN_W-1:0] wr_vpn,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic [VPN_W-1:0] lk_vpn,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn
);
  localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0]            ent_vld;
  logic [ENTRIES-1:0][VPN_W-1:0] ent_vpn;
  logic [ENTRIES-1:0][PPN_W-1:0] ent_ppn;
  logic [PTR_W-1:0]              rr_ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_vld <= '0;
      rr_ptr  <= '0;
    end else if (wr_en) begin
      ent_vld[rr_ptr] <= 1'b1;
      ent_vpn[rr_ptr] <= wr_vpn;
      ent_ppn[rr_ptr] <= wr_ppn;
      rr_ptr <= (rr_ptr == PTR_W'(ENTRIES - 1)) ? '0 : rr_ptr + 1'b1;
    end
  end

  // lowest matching entry wins
  always_comb begin
    lk_hit = 1'b0;
    lk_ppn = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (ent_vld[i] && ent_vpn[i] == lk_vpn) begin
        lk_hit = 1'b1;
        lk_ppn = ent_ppn[i];
      end
    end
  end

  // R8
  rr_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (rr_ptr != $past(rr_ptr)));
endmodule

// File: rtl/vipt_way.sv
module vipt_way #(
  parameter int SETS   = 256,
  parameter int SET_W  = 8,
  parameter int TAG_W  = 20,
  parameter int LINE_W = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SET_W-1:0]  wr_set,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              wr_valid,
  input  logic [LINE_W-1:0] wr_line,
  input  logic              rd_en,
  input  logic [SET_W-1:0]  rd_set,
  output logic              rd_valid,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_line
);
  logic [SETS-1:0]   vld;
  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [LINE_W-1:0] line_mem [SETS];

  always_ff @(posedge clk) begin
    if (!rst_n) vld <= '0;
    else if (wr_en) vld[wr_set] <= wr_valid;
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_mem[wr_set]  <= wr_tag;
      line_mem[wr_set] <= wr_line;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
    end else if (rd_en) begin
      rd_valid <= vld[rd_set];
      rd_tag   <= tag_mem[rd_set];
      rd_line  <= line_mem[rd_set];
    end
  end

  // R9
  line_inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_valid) |=> !vld[$past(wr_set)]);
endmodule

// File: rtl/vipt_hit_sel.sv
module vipt_hit_sel #(
  parameter int WAYS   = 4,
  parameter int WAY_W  = 2,
  parameter int TAG_W  = 20,
  parameter int LINE_W = 128,
  parameter int WORD_W = 32,
  parameter int WSEL_W = 2
) (
  input  logic                        xlat_ok,
  input  logic [TAG_W-1:0]            ppn,
  input  logic [WSEL_W-1:0]           word_sel,
  input  logic [WAYS-1:0]             way_vld,
  input  logic [WAYS-1:0][TAG_W-1:0]  way_tag,
  input  logic [WAYS-1:0][LINE_W-1:0] way_line,
  output logic                        hit,
  output logic [WAY_W-1:0]            hit_way,
  output logic [WORD_W-1:0]           hit_word
);
  logic [WAYS-1:0] match;

  for (genvar w = 0; w < WAYS; w++) begin : g_cmp
    assign match[w] = xlat_ok && way_vld[w] && (way_tag[w] == ppn);
  end

  always_comb begin
    hit      = 1'b0;
    hit_way  = '0;
    hit_word = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w]) begin
        hit      = 1'b1;
        hit_way  = WAY_W'(w);
        hit_word = way_line[w][word_sel*WORD_W +: WORD_W];
      end
    end
  end
endmodule

// File: rtl/vipt_lookup.sv
module vipt_lookup
  import vipt_pkg::*;
#(
  parameter int VA_BITS   = VA_W,
  parameter int PA_BITS   = PA_W,
  parameter int K         = PG_K,
  parameter int B         = BLK_B,
  parameter int L         = IDX_L,
  parameter int WAYS      = N_WAYS,
  parameter int TLB_N     = N_TLB,
  parameter int WORD_BITS = WORD_W,
  localparam int VPN_W  = VA_BITS - K,
  localparam int PPN_W  = PA_BITS - K,
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int LINE_W = 8 * (1 << B),
  localparam int WORDS  = LINE_W / WORD_BITS,
  localparam int WSEL_W = (WORDS > 1) ? $clog2(WORDS) : 1,
  localparam int WLSB   = $clog2(WORD_BITS / 8)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [VA_BITS-1:0]   req_va,
  output logic                 resp_valid,
  output logic                 resp_hit,
  output logic [WAY_W-1:0]     resp_way,
  output logic [WORD_BITS-1:0] resp_data,
  output logic                 resp_tlb_miss,
  input  logic                 tlb_wr_en,
  input  logic [VPN_W-1:0]     tlb_wr_vpn,
  input  logic [PPN_W-1:0]     tlb_wr_ppn,
  input  logic                 line_wr_en,
  input  logic [L-1:0]         line_wr_set,
  input  logic [WAY_W-1:0]     line_wr_way,
  input  logic [PPN_W-1:0]     line_wr_tag,
  input  logic                 line_wr_valid,
  input  logic [LINE_W-1:0]    line_wr_data
);
  // R11: index must stay inside the untranslated page offset
  if (L + B > K) begin : g_bad_geometry
    $error("index plus block offset exceeds page offset");
  end

  logic                 fire;
  logic                 tlb_hit;
  logic [PPN_W-1:0]     tlb_ppn;
  logic                 s1_valid;
  logic                 s1_xlat;
  logic [PPN_W-1:0]     s1_ppn;
  logic [WSEL_W-1:0]    s1_wsel;
  logic [WAYS-1:0]             way_vld;
  logic [WAYS-1:0][PPN_W-1:0]  way_tag;
  logic [WAYS-1:0][LINE_W-1:0] way_line;

  assign req_ready = !(tlb_wr_en || line_wr_en);
  assign fire      = req_valid && req_ready;

  vipt_tlb #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ENTRIES(TLB_N)) u_tlb (
    .clk(clk), .rst_n(rst_n),
    .wr_en(tlb_wr_en), .wr_vpn(tlb_wr_vpn), .wr_ppn(tlb_wr_ppn),
    .lk_vpn(req_va[VA_BITS-1:K]), .lk_hit(tlb_hit), .lk_ppn(tlb_ppn)
  );

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    vipt_way #(.SETS(1 << L), .SET_W(L), .TAG_W(PPN_W), .LINE_W(LINE_W)) u_way (
      .clk(clk), .rst_n(rst_n),
      .wr_en(line_wr_en && line_wr_way == WAY_W'(w)),
      .wr_set(line_wr_set), .wr_tag(line_wr_tag),
      .wr_valid(line_wr_valid), .wr_line(line_wr_data),
      .rd_en(fire), .rd_set(req_va[B+L-1:B]),
      .rd_valid(way_vld[w]), .rd_tag(way_tag[w]), .rd_line(way_line[w])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_xlat  <= 1'b0;
    end else begin
      s1_valid <= fire;
      if (fire) begin
        s1_xlat <= tlb_hit;
        s1_ppn  <= tlb_ppn;
        s1_wsel <= req_va[B-1:WLSB];
      end
    end
  end

  vipt_hit_sel #(.WAYS(WAYS), .WAY_W(WAY_W), .TAG_W(PPN_W), .LINE_W(LINE_W),
                 .WORD_W(WORD_BITS), .WSEL_W(WSEL_W)) u_sel (
    .xlat_ok(s1_valid && s1_xlat), .ppn(s1_ppn), .word_sel(s1_wsel),
    .way_vld(way_vld), .way_tag(way_tag), .way_line(way_line),
    .hit(resp_hit), .hit_way(resp_way), .hit_word(resp_data)
  );

  assign resp_valid    = s1_valid;
  assign resp_tlb_miss = s1_valid && !s1_xlat;

  // R3
  one_cycle_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> resp_valid);
  // R3
  no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> !resp_valid);
  // R2
  write_blocks_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (line_wr_en || tlb_wr_en) |-> !req_ready);
  // R7
  miss_not_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resp_tlb_miss |-> !resp_hit);
  // R10
  zero_on_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !resp_hit |-> (resp_data == '0 && resp_way == '0));
endmodule

// File: tb/vipt_lookup_tb.sv
module vipt_lookup_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid;
  logic         req_ready;
  logic [31:0]  req_va;
  logic         resp_valid, resp_hit, resp_tlb_miss;
  logic [1:0]   resp_way;
  logic [31:0]  resp_data;
  logic         tlb_wr_en;
  logic [19:0]  tlb_wr_vpn, tlb_wr_ppn;
  logic         line_wr_en, line_wr_valid;
  logic [7:0]   line_wr_set;
  logic [1:0]   line_wr_way;
  logic [19:0]  line_wr_tag;
  logic [127:0] line_wr_data;

  int n_tests = 0;
  int n_fail  = 0;

  always #10 clk = ~clk;

  vipt_lookup u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_way(resp_way), .resp_data(resp_data), .resp_tlb_miss(resp_tlb_miss),
    .tlb_wr_en(tlb_wr_en), .tlb_wr_vpn(tlb_wr_vpn), .tlb_wr_ppn(tlb_wr_ppn),
    .line_wr_en(line_wr_en), .line_wr_set(line_wr_set), .line_wr_way(line_wr_way),
    .line_wr_tag(line_wr_tag), .line_wr_valid(line_wr_valid), .line_wr_data(line_wr_data)
  );

  function automatic logic [31:0] pat(input logic [7:0] set, input logic [1:0] way,
                                      input logic [1:0] wd);
    return 32'hD000_0000 | (32'(set) << 8) | (32'(way) << 4) | 32'(wd);
  endfunction

  function automatic logic [127:0] line_of(input logic [7:0] set, input logic [1:0] way);
    return {pat(set, way, 2'd3), pat(set, way, 2'd2), pat(set, way, 2'd1), pat(set, way, 2'd0)};
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic tlb_write(input logic [19:0] vpn, input logic [19:0] ppn);
    @(negedge clk);
    tlb_wr_en = 1'b1; tlb_wr_vpn = vpn; tlb_wr_ppn = ppn;
    @(negedge clk);
    tlb_wr_en = 1'b0;
  endtask

  task automatic line_write(input logic [7:0] set, input logic [1:0] way,
                            input logic [19:0] tag, input logic vld);
    @(negedge clk);
    line_wr_en = 1'b1; line_wr_set = set; line_wr_way = way;
    line_wr_tag = tag; line_wr_valid = vld; line_wr_data = line_of(set, way);
    @(negedge clk);
    line_wr_en = 1'b0;
  endtask

  // one lookup; response sampled at the negedge after the accepting posedge
  task automatic lookup(input string req, input logic [31:0] va, input logic exp_tm,
                        input logic exp_hit, input logic [1:0] exp_way);
    logic [31:0] exp_d;
    exp_d = exp_hit ? pat(va[11:4], exp_way, va[3:2]) : 32'd0;
    @(negedge clk);
    req_valid = 1'b1; req_va = va;
    @(negedge clk);
    req_valid = 1'b0;
    check({req, " valid"}, 64'(resp_valid), 64'd1);
    check({req, " tlb_miss"}, 64'(resp_tlb_miss), 64'(exp_tm));
    check({req, " hit"}, 64'(resp_hit), 64'(exp_hit));
    check({req, " way"}, 64'(resp_way), 64'(exp_hit ? exp_way : 2'd0));
    check({req, " data"}, 64'(resp_data), 64'(exp_d));
  endtask

  typedef struct packed {
    logic [31:0] va;
    logic        tm;
    logic        hit;
    logic [1:0]  way;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{va: 32'h0001_0058, tm: 1'b0, hit: 1'b1, way: 2'd2},  // R4 R5 word 2
    '{va: 32'h0002_005C, tm: 1'b0, hit: 1'b1, way: 2'd0},  // R6 word 3
    '{va: 32'h0001_0FF0, tm: 1'b0, hit: 1'b1, way: 2'd3},  // R4 top set
    '{va: 32'h0002_0FF4, tm: 1'b0, hit: 1'b0, way: 2'd0},  // R5 tag mismatch
    '{va: 32'h0004_0050, tm: 1'b1, hit: 1'b0, way: 2'd0},  // R7
    '{va: 32'h0003_0070, tm: 1'b0, hit: 1'b0, way: 2'd0},  // R10 empty set
    '{va: 32'h0001_0060, tm: 1'b0, hit: 1'b0, way: 2'd0}   // R10
  };

  initial begin
    #4_000_000;
    n_tests++; n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_va = '0;
    tlb_wr_en = 1'b0; tlb_wr_vpn = '0; tlb_wr_ppn = '0;
    line_wr_en = 1'b0; line_wr_set = '0; line_wr_way = '0;
    line_wr_tag = '0; line_wr_valid = 1'b0; line_wr_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 resp_valid after reset", 64'(resp_valid), 64'd0);
    check("R2 ready idle", 64'(req_ready), 64'd1);
    lookup("R1 empty lookup", 32'h0001_0058, 1'b1, 1'b0, 2'd0);

    // translations: entries 0,1,2
    tlb_write(20'h00010, 20'hABCDE);
    tlb_write(20'h00020, 20'h12345);
    tlb_write(20'h00030, 20'h00030);
    line_write(8'h05, 2'd2, 20'hABCDE, 1'b1);
    line_write(8'h05, 2'd0, 20'h12345, 1'b1);
    line_write(8'h05, 2'd1, 20'h00010, 1'b1);  // virtual page as tag: must not hit
    line_write(8'hFF, 2'd3, 20'hABCDE, 1'b1);

    for (int i = 0; i < 7; i++)
      lookup("R5 vector", VECS[i].va, VECS[i].tm, VECS[i].hit, VECS[i].way);

    // R3: response lasts one cycle
    @(negedge clk);
    check("R3 single-cycle response", 64'(resp_valid), 64'd0);

    // R6: another way of another set
    line_write(8'h07, 2'd1, 20'h00030, 1'b1);
    lookup("R6 way1", 32'h0003_0074, 1'b0, 1'b1, 2'd1);

    // R2: request during a write is not taken
    @(negedge clk);
    req_valid = 1'b1; req_va = 32'h0001_0058;
    line_wr_en = 1'b1; line_wr_set = 8'h20; line_wr_way = 2'd0;
    line_wr_tag = 20'h0; line_wr_valid = 1'b0; line_wr_data = '0;
    #1;
    check("R2 ready low during write", 64'(req_ready), 64'd0);
    @(negedge clk);
    req_valid = 1'b0; line_wr_en = 1'b0;
    check("R2 no response to blocked request", 64'(resp_valid), 64'd0);

    // R9: invalidate set 5 way 2
    line_write(8'h05, 2'd2, 20'hABCDE, 1'b0);
    lookup("R9 invalidated line", 32'h0001_0058, 1'b0, 1'b0, 2'd0);
    lookup("R9 neighbour way kept", 32'h0002_0050, 1'b0, 1'b1, 2'd0);

    // R8: fill entries 3..7 then wrap into entry 0
    for (int i = 0; i < 5; i++) tlb_write(20'h00100 + 20'(i), 20'h00200 + 20'(i));
    tlb_write(20'h00050, 20'hABCDE);
    lookup("R8 oldest mapping replaced", 32'h0001_0FF0, 1'b1, 1'b0, 2'd0);
    lookup("R8 new mapping", 32'h0005_0FF8, 1'b0, 1'b1, 2'd3);
    lookup("R8 second mapping kept", 32'h0002_0054, 1'b0, 1'b1, 2'd0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule